// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block forms the byte a flash device drives onto its data bus when the host reads while an internal program or erase algorithm runs. A command decoder elsewhere reports the current operation through `op_state`, and it pulses `op_start` in the cycle that marks the rising edge of the last write strobe of a command sequence. The block combines that state with a few condition flags and with the byte being programmed. Each host read appears as a one-cycle `rd_stb`. The block answers it with a status byte or, when no algorithm is visible, with the array data supplied from outside.

Two toggle bits advance once per read strobe and not once per clock. The "busy" toggle (bit 6) and the "erase-sector" toggle (bit 2) each live in their own domain and have their own advance condition. A program or erase aimed at a protected target is silently dropped. The block still makes such an operation look busy for a fixed window counted in clock cycles. The window is derived from the clock frequency parameter, and once it ends, reads fall back to array data.

`op_state` encoding: 0 idle, 1 programming, 2 erasing, 3 erase-suspended.

Top module: `flash_status_responder`

## Requirements
- R1: `status_q` is 0 after reset. It changes only on the clock edge that samples `rd_stb` high, and it holds its value in every other cycle.
- R2: With `op_state` = 0 and no protection window running, a read returns `array_data`.
- R3: While programming (`op_state` = 1), a read returns bit 7 = inverse of `prog_data[7]`, bit 6 = busy toggle, bit 5 = `time_over`, and bits 4..0 = 0.
- R4: While erasing (`op_state` = 2), a read returns bit 7 = 0, bit 6 = busy toggle, bit 5 = `time_over`, bit 3 = `win_expired`, bit 2 = erase-sector toggle when `addr_in_erase` is 1 (else 0), and bits 4, 1 and 0 = 0.
- R5: The busy toggle reports 0 on the first read after `op_start`. It inverts on each read made while programming or erasing.
- R6: The erase-sector toggle advances only on reads with `addr_in_erase` = 1 while erasing or erase-suspended. Reads with `addr_in_erase` = 0 neither advance it nor show it.
- R7: While erase-suspended (`op_state` = 3), a read with `addr_in_erase` = 1 returns bits 7 and 6 = 1, bit 2 = erase-sector toggle, and all other bits 0. A read with `addr_in_erase` = 0 returns `array_data`. The busy toggle does not advance in this state.
- R8: `op_start` clears both toggles to 0.
- R9: An `op_start` with `tgt_prot` = 1 and `op_state` = 1 shows program status for the CLK_MHZ × PROG_WIN_US clock edges after the start edge. After that, reads return `array_data` whatever `op_state` says, until the next `op_start`.
- R10: An `op_start` with `tgt_prot` = 1 and `op_state` = 2 shows erase status for the CLK_MHZ × ERASE_WIN_US edges after the start edge. After that, reads return `array_data` until the next `op_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_state | input | 2 | Operation state: 0 idle, 1 program, 2 erase, 3 erase-suspended |
| op_start | input | 1 | One-cycle pulse at the final write strobe of a command |
| tgt_prot | input | 1 | Target of the starting operation is protected (sampled with op_start) |
| time_over | input | 1 | Operation exceeded its time limit |
| win_expired | input | 1 | Erase command window has closed and erasure is active |
| addr_in_erase | input | 1 | Current read address lies in a sector selected for erase |
| prog_data | input | 8 | Byte being programmed |
| array_data | input | 8 | Array contents at the read address |
| rd_stb | input | 1 | One-cycle read strobe |
| status_q | output | 8 | Registered status or array byte |

## Verification
Each response is due on the clock edge that samples `rd_stb` high. The bench drives inputs on falling edges and compares `status_q` on the next falling edge. A toggle advance shows up only in the response to the following read. A protection window started on edge E0 covers the reads sampled on E1 through EN. The directed checks therefore wait exactly N−1 falling edges after the start before reading, which lands a read on the last edge inside the window and the next read on the first edge outside it. A behavioural reference model tracks toggles, window count and latched protection on every edge, and it is compared on every falling edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_PROG  = 2'd1,
      OP_ERASE = 2'd2,
      OP_SUSP  = 2'd3
   } op_e;

   localparam int TOG_BUSY  = 0;
   localparam int TOG_ESECT = 1;
   localparam int TOG_N     = 2;
endpackage

// File: rtl/fsr_guard_timer.sv
module fsr_guard_timer #(
   parameter int PROG_CYC  = 250,
   parameter int ERASE_CYC = 25000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic load_prog,
   input  logic load_erase,
   output logic active
);
   localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] PROG_V  = CNT_W'(PROG_CYC);
   localparam logic [CNT_W-1:0] ERASE_V = CNT_W'(ERASE_CYC);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         if (load_prog)
            cnt_q <= PROG_V;
         else if (load_erase)
            cnt_q <= ERASE_V;
         else
            cnt_q <= '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active = (cnt_q != '0);
endmodule

// File: rtl/fsr_toggle_bank.sv
module fsr_toggle_bank #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] adv,
   output logic [N-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_dom
      always_ff @(posedge clk) begin
         if (!rst_n || clr)
            q[i] <= 1'b0;
         else if (adv[i])
            q[i] <= ~q[i];
      end
   end
endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
   import fsr_pkg::*;
(
   input  op_e        eff,
   input  logic       addr_in_erase,
   input  logic       prog_d7,
   input  logic       time_over,
   input  logic       win_expired,
   input  logic       tog_busy,
   input  logic       tog_esect,
   input  logic [7:0] array_data,
   output logic [7:0] byte_o
);
   logic esect_bit;
   assign esect_bit = addr_in_erase & tog_esect;

   always_comb begin
      unique case (eff)
         OP_PROG:  byte_o = {~prog_d7, tog_busy, time_over, 5'b0};
         OP_ERASE: byte_o = {1'b0, tog_busy, time_over, 1'b0,
                             win_expired, esect_bit, 2'b0};
         OP_SUSP:  byte_o = addr_in_erase ? {2'b11, 3'b0, esect_bit, 2'b0}
                                          : array_data;
         default:  byte_o = array_data;
      endcase
   end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
   import fsr_pkg::*;
#(
   parameter int CLK_MHZ      = 250,
   parameter int PROG_WIN_US  = 1,
   parameter int ERASE_WIN_US = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] op_state,
   input  logic       op_start,
   input  logic       tgt_prot,
   input  logic       time_over,
   input  logic       win_expired,
   input  logic       addr_in_erase,
   input  logic [7:0] prog_data,
   input  logic [7:0] array_data,
   input  logic       rd_stb,
   output logic [7:0] status_q
);
   localparam int PROG_CYC  = CLK_MHZ * PROG_WIN_US;
   localparam int ERASE_CYC = CLK_MHZ * ERASE_WIN_US;

   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("CLK_MHZ must be at least 1");
   end
   if (PROG_WIN_US < 1 || ERASE_WIN_US < 1) begin : g_bad_win
      $error("protection windows must be at least 1 us");
   end

   op_e              op_in;
   op_e              kind_q;
   op_e              eff_state;
   logic             prot_q;
   logic             win_active;
   logic             is_prot_start;
   logic [TOG_N-1:0] tog_q;
   logic [TOG_N-1:0] tog_adv;
   logic [7:0]       resp;
   logic [1:0]       eff_bits;

   assign op_in         = op_e'(op_state);
   assign is_prot_start = op_start & tgt_prot &
                          ((op_in == OP_PROG) || (op_in == OP_ERASE));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot_q <= 1'b0;
         kind_q <= OP_IDLE;
      end else if (op_start) begin
         prot_q <= is_prot_start;
         kind_q <= op_in;
      end
   end

   fsr_guard_timer #(
      .PROG_CYC  (PROG_CYC),
      .ERASE_CYC (ERASE_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (op_start),
      .load_prog  (is_prot_start && (op_in == OP_PROG)),
      .load_erase (is_prot_start && (op_in == OP_ERASE)),
      .active     (win_active)
   );

   always_comb begin
      if (win_active)
         eff_state = kind_q;
      else if (prot_q)
         eff_state = OP_IDLE;
      else
         eff_state = op_in;
   end
   assign eff_bits = eff_state;

   assign tog_adv[TOG_BUSY]  = rd_stb &&
                               ((eff_state == OP_PROG) || (eff_state == OP_ERASE));
   assign tog_adv[TOG_ESECT] = rd_stb && addr_in_erase &&
                               ((eff_state == OP_ERASE) || (eff_state == OP_SUSP));

   fsr_toggle_bank #(.N(TOG_N)) u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (op_start),
      .adv   (tog_adv),
      .q     (tog_q)
   );

   fsr_status_mux u_mux (
      .eff           (eff_state),
      .addr_in_erase (addr_in_erase),
      .prog_d7       (prog_data[7]),
      .time_over     (time_over),
      .win_expired   (win_expired),
      .tog_busy      (tog_q[TOG_BUSY]),
      .tog_esect     (tog_q[TOG_ESECT]),
      .array_data    (array_data),
      .byte_o        (resp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         status_q <= '0;
      else if (rd_stb)
         status_q <= resp;
   end
endmodule

// File: rtl/fsr_status_checker.sv
module fsr_status_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_stb,
   input logic       op_start,
   input logic       time_over,
   input logic [1:0] eff,
   input logic [1:0] tog,
   input logic [7:0] status_q
);
   a_r1_hold_between_reads: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(status_q));

   a_r4_erase_bit7_low: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && eff == 2'd2) |=> !status_q[7]);

   a_r3_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && time_over && (eff == 2'd1 || eff == 2'd2)) |=> status_q[5]);

   a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> (tog == 2'b00));

   a_r7_busy_frozen_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (eff == 2'd3 && !op_start) |=> (tog[0] == $past(tog[0])));

   a_r2_idle_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (eff == 2'd0 && !op_start) |=> $stable(tog));
endmodule

bind flash_status_responder fsr_status_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_stb    (rd_stb),
   .op_start  (op_start),
   .time_over (time_over),
   .eff       (eff_bits),
   .tog       (tog_q),
   .status_q  (status_q)
);

// File: tb/flash_status_responder_bench.sv
`timescale 1ns/1ps
module flash_status_responder_bench;
   localparam int CLK_MHZ = 250;
   localparam int NPROG   = CLK_MHZ * 1;
   localparam int NERASE  = CLK_MHZ * 100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_state = 2'd0;
   logic       op_start = 1'b0;
   logic       tgt_prot = 1'b0;
   logic       time_over = 1'b0;
   logic       win_expired = 1'b0;
   logic       addr_in_erase = 1'b0;
   logic [7:0] prog_data = 8'h00;
   logic [7:0] array_data = 8'h5A;
   logic       rd_stb = 1'b0;
   logic [7:0] status_q;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   flash_status_responder #(.CLK_MHZ(CLK_MHZ)) u_flash_status_responder (
      .clk(clk), .rst_n(rst_n), .op_state(op_state), .op_start(op_start),
      .tgt_prot(tgt_prot), .time_over(time_over), .win_expired(win_expired),
      .addr_in_erase(addr_in_erase), .prog_data(prog_data),
      .array_data(array_data), .rd_stb(rd_stb), .status_q(status_q)
   );

   // behavioural reference model
   int         m_win = 0;
   int         m_kind = 0;
   int         m_eff = 0;
   bit         m_prot = 0;
   bit         m_t6 = 0;
   bit         m_t2 = 0;
   logic [7:0] m_exp = 8'h00;

   function automatic logic [7:0] model_byte(int eff, bit t6, bit t2);
      logic [7:0] b;
      b = 8'h00;
      case (eff)
         1: begin
            b[7] = ~prog_data[7]; b[6] = t6; b[5] = time_over;
         end
         2: begin
            b[6] = t6; b[5] = time_over; b[3] = win_expired;
            b[2] = addr_in_erase ? t2 : 1'b0;
         end
         3: begin
            if (addr_in_erase) begin
               b[7] = 1'b1; b[6] = 1'b1; b[2] = t2;
            end else begin
               b = array_data;
            end
         end
         default: b = array_data;
      endcase
      return b;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_win = 0; m_kind = 0; m_prot = 0; m_t6 = 0; m_t2 = 0; m_exp = 8'h00;
      end else begin
         if (m_win > 0)   m_eff = m_kind;
         else if (m_prot) m_eff = 0;
         else             m_eff = int'(op_state);
         if (rd_stb) m_exp = model_byte(m_eff, m_t6, m_t2);
         if (op_start) begin
            m_t6 = 0; m_t2 = 0;
            m_prot = tgt_prot && (op_state == 2'd1 || op_state == 2'd2);
            m_kind = int'(op_state);
            m_win  = !m_prot ? 0 : (op_state == 2'd1 ? NPROG : NERASE);
         end else begin
            if (rd_stb && (m_eff == 1 || m_eff == 2)) m_t6 = ~m_t6;
            if (rd_stb && addr_in_erase && (m_eff == 2 || m_eff == 3)) m_t2 = ~m_t2;
            if (m_win > 0) m_win = m_win - 1;
         end
      end
   end

   // R1: every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if (status_q !== m_exp) begin
            n_bad++;
            $display("FAIL R1 model compare: status_q=%h expected=%h at %0t",
                     status_q, m_exp, $time);
         end
      end
   end

   task automatic chk(input logic [7:0] exp, input string tag);
      n_cmp++;
      if (status_q !== exp) begin
         n_bad++;
         $display("FAIL %s: status_q=%h expected=%h", tag, status_q, exp);
      end
   endtask

   task automatic do_read(input logic [7:0] exp, input string tag);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      chk(exp, tag);
   endtask

   task automatic start_op(input logic [1:0] st, input logic prot);
      op_state = st;
      tgt_prot = prot;
      op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0;
      tgt_prot = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(8'h00, "R1 reset value");

      // R2 idle read returns array data
      do_read(8'h5A, "R2 idle array read");
      @(negedge clk);
      chk(8'h5A, "R1 hold without strobe");

      // R3 / R5 programming
      prog_data = 8'h80;
      start_op(2'd1, 1'b0);
      do_read(8'h00, "R5 first busy toggle 0 / R3 inverted bit7");
      do_read(8'h40, "R5 busy toggle inverts");
      time_over = 1'b1;
      do_read(8'h20, "R3 timeout flag");
      prog_data = 8'h00;
      do_read(8'hE0, "R3 bit7 inverse of data");
      time_over = 1'b0;

      // R4 / R6 erasing
      win_expired   = 1'b1;
      addr_in_erase = 1'b1;
      start_op(2'd2, 1'b0);
      do_read(8'h08, "R4 erase first read");
      do_read(8'h4C, "R6 erase-sector toggle advances");
      addr_in_erase = 1'b0;
      do_read(8'h08, "R6 no show off erasing sector");
      addr_in_erase = 1'b1;
      do_read(8'h48, "R6 toggle not advanced by off-sector read");

      // R7 suspend
      op_state = 2'd3;
      do_read(8'hC4, "R7 suspended sector read");
      do_read(8'hC0, "R7 bit2 toggles in suspend");
      addr_in_erase = 1'b0;
      array_data = 8'h33;
      do_read(8'h33, "R7 non-suspended sector array data");
      addr_in_erase = 1'b1;
      op_state = 2'd2;
      do_read(8'h0C, "R7 busy toggle frozen across suspend");

      // R8 new op clears toggles
      win_expired = 1'b0;
      start_op(2'd2, 1'b0);
      do_read(8'h00, "R8 toggles cleared at start");

      // R2 back to idle
      op_state = 2'd0;
      addr_in_erase = 1'b0;
      array_data = 8'h5A;
      do_read(8'h5A, "R2 idle after operation");

      // R9 protected program window boundary
      prog_data = 8'h00;
      start_op(2'd1, 1'b1);
      repeat (NPROG - 1) @(negedge clk);
      do_read(8'h80, "R9 last cycle of protected program window");
      do_read(8'h5A, "R9 array data after window");

      // R10 protected erase window boundary
      start_op(2'd2, 1'b1);
      do_read(8'h00, "R10 protected erase shows busy");
      repeat (NERASE - 2) @(negedge clk);
      do_read(8'h40, "R10 last cycle of protected erase window");
      do_read(8'h5A, "R10 array data after window");

      @(negedge clk);
      finish_run();
   end
endmodule